// File: doc/BRIEF.md
# Descriptor-Driven SPI Command Engine

This block is an SPI master that needs no byte-by-byte attention from software. For each transaction, software places a fixed-format command descriptor in on-chip memory. It then writes the descriptor's address into one of two per-channel pointer registers and sets a start bit. The engine reads the descriptor over a simple synchronous memory port. It shifts out up to sixteen inline command bytes. After that it does one of two things: it streams a tail of write data from a memory buffer, or it clocks in a number of read bytes and stores them into a per-channel receive buffer. When the command is finished it raises a bus-end status flag and an optional interrupt.

Each channel drives its own active-low chip select. A hold flag in the descriptor keeps chip select asserted after the command. Software can therefore chain several descriptors, for example a command phase and then a data phase, into one framed SPI transaction. The serial link uses 8-bit words, one data line in each direction and clock phase 0. Data leaves MSB first, SCK rests low, MOSI changes after a falling edge and MISO is sampled on the rising edge.

Top module: `spi_desc_engine`

## Requirements
- R1: After reset, `cs_n` is 2'b11, `sck`, `mosi` and `irq` are 0, and every register reads 0.
- R2: A descriptor is laid out as follows. Byte 0 is the inline length; a value above 16 is treated as 16. Byte 1 is the command: bit 1 = 1 means read, bit 3 = 1 means hold chip select. Bytes 2 and 3 are a 16-bit data length, low byte first. Bytes 4 and 5 are a 16-bit data address, low byte first, and byte 6 bits 1:0 are data address bits 17:16. The inline bytes start at descriptor offset 8.
- R3: The register map uses a 5-bit address. 0x00 is control: bit 0 enable, bit 1 interrupt enable, bit 4 start channel 0, bit 5 start channel 1. 0x01 is status: bit 0 bus end, bit 7 busy (read only). The descriptor pointer bytes are at 0x08 to 0x0A for channel 0 and 0x18 to 0x1A for channel 1. The receive pointer bytes are at 0x0C to 0x0E for channel 0 and 0x1C to 0x1E for channel 1, low byte first. All of these read back what was written.
- R4: A command starts when enable and a channel start bit are both 1. That channel's start bit clears itself when the command ends.
- R5: A write command (bit 1 = 0) sends the inline bytes and then the data-length bytes read from the data address. Each byte goes out MSB first; MOSI is stable at every rising SCK edge.
- R6: A read command (bit 1 = 1) sends the inline bytes and then clocks in data-length bytes. These bytes are stored at consecutive addresses from the channel's receive pointer.
- R7: Only the running channel's chip select is low while SCK toggles. It returns high once the command ends, unless hold was set. With hold set it stays low until a command without hold ends on that channel.
- R8: At the end of every command, status bit 0 is set. Writing 1 to it clears it and writing 0 does not. `irq` equals status bit 0 AND interrupt enable.
- R9: While busy, status bit 7 reads 1 and writes to control bits 0, 4 and 5 are ignored; bit 1 still takes the written value.
- R10: A command with zero inline bytes and zero data length produces no SCK edge but still sets bus end.
- R11: One SCK period is 2*HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Bus-end interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects, one per channel |

## Verification
The assertions take several things about the environment for granted. Memory must return read data exactly one cycle after a read request. Software must keep the two channels' holds from overlapping. A status write and a bus-end event must not fall in the same cycle for the clear check to apply. The bench's memory model answers with the fixed one-cycle latency. It runs one channel at a time and waits for busy to drop before it touches the status register. The bench's SPI slave changes MISO only on falling SCK edges.

// File: rtl/spi_de_pkg.sv
// Shared constants and the sequencer state type for the SPI descriptor engine.
package spi_de_pkg;
    localparam int INLINE_MAX  = 16;  // largest inline payload
    localparam int INLINE_OFS  = 8;   // descriptor offset of the inline bytes
    localparam int HDR_LAST    = 6;   // last descriptor header byte fetched
    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h01;
    localparam int CB_EN   = 0;
    localparam int CB_IEN  = 1;
    localparam int CB_SEL0 = 4;
    localparam int CMD_RD   = 1;
    localparam int CMD_HOLD = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_DREQ, S_DCAP, S_NEXT, S_TREQ, S_TCAP, S_SHIFT, S_STORE, S_END
    } seq_state_t;
endpackage

// File: rtl/spi_de_regs.sv
// Register file: control, W1C status and per-channel 24-bit pointers.
// Assumes end_pulse is a single-cycle strobe from the sequencer.
module spi_de_regs
    import spi_de_pkg::*;
#(
    parameter int N_CH      = 2,
    parameter int PTR_BYTES = 3,
    localparam int PW = 8 * PTR_BYTES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [4:0]               addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic                     busy,
    input  logic                     end_pulse,
    input  logic                     end_ch,
    output logic                     go_en,
    output logic [N_CH-1:0]          sel,
    output logic [N_CH-1:0][PW-1:0]  desc_ptr,
    output logic [N_CH-1:0][PW-1:0]  rx_ptr,
    output logic                     irq
);
    logic                                       en_q, ien_q, stat_q;
    logic [N_CH-1:0][1:0][PTR_BYTES-1:0][7:0]   ptr_q;

    // Control bits: start/enable locked while busy, select cleared at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; ien_q <= 1'b0; sel <= '0;
        end else begin
            if (we && addr == A_CTRL) begin
                ien_q <= wdata[CB_IEN];
                if (!busy) begin
                    en_q <= wdata[CB_EN];
                    sel  <= wdata[CB_SEL0 +: N_CH];
                end
            end
            if (end_pulse) sel[end_ch] <= 1'b0;
        end
    end

    // Bus-end status: set by the sequencer, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else if (end_pulse) stat_q <= 1'b1;
        else if (we && addr == A_STAT && wdata[0]) stat_q <= 1'b0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        for (genvar k = 0; k < 2; k++) begin : g_kind
            for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
                // Pointer byte write.
                always_ff @(posedge clk) begin
                    if (!rst_n) ptr_q[c][k][b] <= '0;
                    else if (we && addr[3] && addr[4] == 1'(c) && addr[2] == 1'(k)
                             && addr[1:0] == 2'(b))
                        ptr_q[c][k][b] <= wdata;
                end
            end
        end
        assign desc_ptr[c] = ptr_q[c][0];
        assign rx_ptr[c]   = ptr_q[c][1];
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[CB_EN] = en_q; rdata[CB_IEN] = ien_q;
            rdata[CB_SEL0 +: N_CH] = sel;
        end else if (addr == A_STAT) begin
            rdata = {busy, 6'b0, stat_q};
        end else if (addr[3]) begin
            for (int c = 0; c < N_CH; c++)
                for (int b = 0; b < PTR_BYTES; b++)
                    if (addr[4] == 1'(c) && addr[1:0] == 2'(b))
                        rdata = addr[2] ? ptr_q[c][1][b] : ptr_q[c][0][b];
        end
    end

    assign go_en = en_q;
    assign irq   = stat_q & ien_q;

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_STAT && wdata[0] && !end_pulse) |=> !stat_q);
    a_r9_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !end_pulse) |=> ($stable(en_q) && $stable(sel)));
    a_r8_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> stat_q);
endmodule

// File: rtl/spi_de_shift.sv
// Byte serializer, SPI mode 0, MSB first. SCK half period is HALF_DIV cycles.
// Assumes start is only raised while not busy; done pulses once per byte.
module spi_de_shift #(
    parameter int HALF_DIV = 2,
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx,
    output logic       busy
);
    logic          act;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    // Half-period timer, edge generation, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0; cnt <= '0; bitn <= '0; sh <= '0;
            sck <= 1'b0; done <= 1'b0; rx <= '0;
        end else begin
            done <= 1'b0;
            if (start && !act) begin
                act <= 1'b1; sh <= tx; bitn <= '0; cnt <= '0; sck <= 1'b0;
            end else if (act) begin
                if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            act <= 1'b0; done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign mosi = act & sh[7];
    assign busy = act;

    a_r5_sck_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !sck);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spi_de_seq.sv
// Sequencer: fetches the descriptor header, feeds bytes to the serializer,
// stores received bytes and drives chip selects.
// Assumes memory read data arrives one cycle after a read request.
module spi_de_seq
    import spi_de_pkg::*;
#(
    parameter int N_CH = 2,
    parameter int AW   = 18,
    parameter int PW   = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go_en,
    input  logic [N_CH-1:0]          sel,
    input  logic [N_CH-1:0][PW-1:0]  desc_ptr,
    input  logic [N_CH-1:0][PW-1:0]  rx_ptr,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata,
    output logic                     sh_start,
    output logic [7:0]               sh_tx,
    input  logic                     sh_done,
    input  logic [7:0]               sh_rx,
    output logic                     busy,
    output logic                     end_pulse,
    output logic                     end_ch,
    output logic [N_CH-1:0]          cs_n
);
    seq_state_t      state;
    logic            ch;
    logic [AW-1:0]   dbase, rbase;
    logic [2:0]      idx;
    logic [4:0]      n_in;
    logic [7:0]      cmd;
    logic [15:0]     dlen;
    logic [7:0]      dlo, dhi;
    logic [1:0]      dtop;
    logic [16:0]     j, total, tail_ofs;
    logic [N_CH-1:0] cs_on;
    logic            rx_phase, pick;

    assign total    = 17'(n_in) + 17'(dlen);
    assign tail_ofs = j - 17'(n_in);
    assign rx_phase = cmd[CMD_RD] && (j >= 17'(n_in));
    assign pick     = ~sel[0];

    // Main command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; ch <= 1'b0; dbase <= '0; rbase <= '0; idx <= '0;
            n_in <= '0; cmd <= '0; dlen <= '0; dlo <= '0; dhi <= '0; dtop <= '0;
            j <= '0; cs_on <= '0;
        end else begin
            if (sh_start) cs_on[ch] <= 1'b1;
            case (state)
                S_IDLE: if (go_en && |sel) begin
                    ch <= pick; dbase <= AW'(desc_ptr[pick]); rbase <= AW'(rx_ptr[pick]);
                    idx <= '0; j <= '0; state <= S_DREQ;
                end
                S_DREQ: state <= S_DCAP;
                S_DCAP: begin
                    case (idx)
                        3'd0: n_in <= (mem_rdata > 8'(INLINE_MAX)) ? 5'(INLINE_MAX) : mem_rdata[4:0];
                        3'd1: cmd <= mem_rdata;
                        3'd2: dlen[7:0] <= mem_rdata;
                        3'd3: dlen[15:8] <= mem_rdata;
                        3'd4: dlo <= mem_rdata;
                        3'd5: dhi <= mem_rdata;
                        default: dtop <= mem_rdata[1:0];
                    endcase
                    idx   <= idx + 3'd1;
                    state <= (idx == 3'(HDR_LAST)) ? S_NEXT : S_DREQ;
                end
                S_NEXT: if (j < total) state <= rx_phase ? S_SHIFT : S_TREQ;
                        else state <= S_END;
                S_TREQ: state <= S_TCAP;
                S_TCAP: state <= S_SHIFT;
                S_SHIFT: if (sh_done) begin
                    if (rx_phase) state <= S_STORE;
                    else begin j <= j + 17'd1; state <= S_NEXT; end
                end
                S_STORE: begin j <= j + 17'd1; state <= S_NEXT; end
                S_END: begin
                    if (!cmd[CMD_HOLD]) cs_on[ch] <= 1'b0;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory address and strobe selection per state.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (state)
            S_DREQ: begin mem_req = 1'b1; mem_addr = dbase + AW'(idx); end
            S_TREQ: begin
                mem_req  = 1'b1;
                mem_addr = (j < 17'(n_in)) ? dbase + AW'(INLINE_OFS) + AW'(j)
                                           : AW'({dtop, dhi, dlo}) + AW'(tail_ofs);
            end
            S_STORE: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = rbase + AW'(tail_ofs); end
            default: ;
        endcase
    end

    assign mem_wdata = sh_rx;
    assign sh_start  = (state == S_TCAP) || (state == S_NEXT && j < total && rx_phase);
    assign sh_tx     = (state == S_TCAP) ? mem_rdata : 8'h00;
    assign busy      = (state != S_IDLE);
    assign end_pulse = (state == S_END);
    assign end_ch    = ch;
    assign cs_n      = ~cs_on;

    a_r6_store_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cmd[CMD_RD]);
    a_r8_end_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> !end_pulse);
    a_r7_release_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && !cmd[CMD_HOLD]) |=> cs_n[end_ch]);
endmodule

// File: rtl/spi_desc_engine.sv
// Top level: register file, descriptor sequencer and byte serializer.
// Assumes a synchronous byte memory with one-cycle read latency.
module spi_desc_engine #(
    parameter int AW       = 18,
    parameter int HALF_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic [1:0]    cs_n
);
    localparam int N_CH = 2;
    localparam int PTR_BYTES = 3;
    localparam int PW = 8 * PTR_BYTES;

    logic                    busy, end_pulse, end_ch, go_en;
    logic [N_CH-1:0]         sel;
    logic [N_CH-1:0][PW-1:0] desc_ptr, rx_ptr;
    logic                    sh_start, sh_done, sh_busy;
    logic [7:0]              sh_tx, sh_rx;

    spi_de_regs #(.N_CH(N_CH), .PTR_BYTES(PTR_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .end_pulse(end_pulse), .end_ch(end_ch),
        .go_en(go_en), .sel(sel), .desc_ptr(desc_ptr), .rx_ptr(rx_ptr), .irq(irq));

    spi_de_seq #(.N_CH(N_CH), .AW(AW), .PW(PW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_en(go_en), .sel(sel), .desc_ptr(desc_ptr),
        .rx_ptr(rx_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sh_start(sh_start),
        .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx), .busy(busy),
        .end_pulse(end_pulse), .end_ch(end_ch), .cs_n(cs_n));

    spi_de_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .done(sh_done), .rx(sh_rx), .busy(sh_busy));

    a_r7_cs_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&cs_n));
    a_r5_shift_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> busy);
endmodule

// File: tb/spi_desc_engine_tb.sv
`timescale 1ns/100ps
module spi_desc_engine_tb;
    localparam int HALF = 2;
    logic clk = 0, rst_n = 0;
    logic reg_we = 0; logic [4:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata, mem_wdata, mem_rdata;
    logic irq, mem_req, mem_we, sck, mosi, miso;
    logic [17:0] mem_addr; logic [1:0] cs_n;
    logic [7:0] mem [0:4095];
    logic [7:0] cap [0:63];
    int nchk = 0, nerr = 0, cyc = 0, nb = 0, mi_bit = 0, exp_ch = 0, cs_bad = 0;
    int rise1 = 0, rise2 = 0;
    logic [7:0] bitsh = 0;

    always #2 clk = ~clk;

    spi_desc_engine #(.AW(18), .HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    function automatic logic [7:0] slv(int k); return 8'((k * 37 + 11) & 255); endfunction
    function automatic logic [7:0] inl(int j, int n); return 8'((j * 29 + n * 3 + 1) & 255); endfunction
    function automatic logic [7:0] tl(int i, int l); return 8'((i * 13 + l + 7) & 255); endfunction
    function automatic logic sbit(int b);
        logic [7:0] v; v = slv(b / 8); return v[7 - (b % 8)];
    endfunction
    assign miso = sbit(mi_bit);

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
            else mem_rdata = mem[mem_addr[11:0]];
        end
    end

    // SPI slave monitor: capture MOSI on rising edges, advance MISO on falling.
    always @(posedge sck) begin
        bitsh = {bitsh[6:0], mosi};
        nb = nb + 1;
        if (nb == 1) rise1 = cyc;
        if (nb == 2) rise2 = cyc;
        if (nb % 8 == 0 && nb <= 512) cap[nb / 8 - 1] = bitsh;
        if (cs_n[exp_ch] || !cs_n[1 - exp_ch]) cs_bad = cs_bad + 1;
    end
    always @(negedge sck) mi_bit = mi_bit + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = 8'(d);
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk); reg_addr = 5'(a); #1 v = reg_rdata;
    endtask

    task automatic put_desc(input int a, input int n, input int cmd, input int l, input int da);
        mem[a] = 8'(n); mem[a+1] = 8'(cmd); mem[a+2] = 8'(l & 255); mem[a+3] = 8'(l >> 8);
        mem[a+4] = 8'(da & 255); mem[a+5] = 8'((da >> 8) & 255); mem[a+6] = 0; mem[a+7] = 0;
        for (int j = 0; j < n; j++) mem[a+8+j] = inl(j, n);
        if (!cmd[1]) for (int i = 0; i < l; i++) mem[da+i] = tl(i, l);
    endtask

    task automatic launch(input int ch, input int dp, input int rp, input int ctrl);
        int base; base = ch ? 8'h18 : 8'h08;
        for (int b = 0; b < 3; b++) begin
            wr(base + b, (dp >> (8*b)) & 255);
            wr(base + 4 + b, (rp >> (8*b)) & 255);
        end
        nb = 0; mi_bit = 0; exp_ch = ch; cs_bad = 0;
        wr(0, ctrl);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        repeat (3) @(negedge clk);
        do rd(1, s); while (s[7]);
    endtask

    // Checks one finished command: stream, chip selects, bus end.
    task automatic check_cmd(input int n, input bit rdc, input int l, input int base_rx, input string tag);
        int ni, bad; logic [7:0] s, e;
        ni = (n > 16) ? 16 : n; bad = 0;
        chk(nb == 8 * (ni + l), {tag, " bit count"}, nb, 8 * (ni + l));
        for (int k = 0; k < ni + l && k < 64; k++) begin
            e = (k < ni) ? inl(k, n) : (rdc ? 8'h00 : tl(k - ni, l));
            if (cap[k] !== e) bad++;
        end
        chk(bad == 0, {tag, " MOSI byte stream"}, bad, 0);
        chk(cs_bad == 0, "R7 only running channel selected", cs_bad, 0);
        rd(1, s);
        chk(s[0] == 1, "R8 bus end set", s, 1);
        if (rdc) begin
            bad = 0;
            for (int i = 0; i < l; i++) if (mem[base_rx + i] !== slv(ni + i)) bad++;
            chk(bad == 0, "R6 stored read bytes", bad, 0);
        end
        wr(1, 1);
    endtask

    initial begin
        logic [7:0] v;
        int lens[3] = '{0, 2, 5};
        int ins[5]  = '{0, 1, 3, 16, 21};
        for (int i = 0; i < 4096; i++) mem[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 2'b11 && !sck && !mosi && !irq, "R1 reset outputs", {cs_n, sck, mosi, irq}, 5'b11000);
        rst_n = 1;
        rd(0, v); chk(v == 0, "R1 ctrl reset", v, 0);
        rd(1, v); chk(v == 0, "R1 status reset", v, 0);
        rd(8'h1E, v); chk(v == 0, "R1 pointer reset", v, 0);
        // R3 pointer readback
        wr(8'h1D, 8'hC3); rd(8'h1D, v); chk(v == 8'hC3, "R3 pointer readback", v, 8'hC3);
        rd(8'h0D, v); chk(v == 0, "R3 other channel untouched", v, 0);
        // R2 R5 R10 write sweep over inline and tail lengths on channel 0
        foreach (ins[a]) foreach (lens[b]) begin
            put_desc(12'h100, ins[a], 8'h01, lens[b], 12'h400);
            launch(0, 12'h100, 12'h800, 8'h13);
            wait_idle();
            check_cmd(ins[a], 0, lens[b], 0, (ins[a] + lens[b] == 0) ? "R10" : "R5");
            rd(0, v); chk(v == 8'h03, "R4 select self-clears", v, 8'h03);
        end
        // R11 SCK period
        put_desc(12'h100, 1, 8'h01, 0, 0);
        launch(0, 12'h100, 0, 8'h13); wait_idle();
        chk(rise2 - rise1 == 2 * HALF, "R11 sck period", rise2 - rise1, 2 * HALF);
        wr(1, 1);
        // R6 read on channel 1 with interrupt
        put_desc(12'h200, 2, 8'h03, 6, 0);
        launch(1, 12'h200, 12'h900, 8'h23); wait_idle();
        chk(irq == 1, "R8 irq follows bus end", irq, 1);
        rd(1, v); wr(1, 0); rd(1, v);
        chk(v[0] == 1, "R8 writing 0 keeps status", v, 1);
        check_cmd(2, 1, 6, 12'h900, "R6");
        chk(irq == 0, "R8 irq cleared", irq, 0);
        // R7 hold chains two descriptors
        put_desc(12'h300, 2, 8'h09, 0, 0);
        launch(0, 12'h300, 0, 8'h11); wait_idle();
        chk(cs_n == 2'b10, "R7 hold keeps cs low", cs_n, 2'b10);
        wr(1, 1);
        put_desc(12'h340, 1, 8'h01, 0, 0);
        launch(0, 12'h340, 0, 8'h11); wait_idle();
        chk(cs_n == 2'b11, "R7 released after non-hold", cs_n, 2'b11);
        wr(1, 1);
        // R9 busy lock
        put_desc(12'h100, 16, 8'h01, 5, 12'h400);
        launch(0, 12'h100, 0, 8'h13);
        repeat (5) @(negedge clk);
        rd(1, v); chk(v[7] == 1, "R9 busy flag", v, 8'h80);
        wr(0, 8'h20);
        wait_idle();
        rd(0, v); chk(v == 8'h01, "R9 start bits ignored while busy", v, 8'h01);
        nb = 0; repeat (60) @(negedge clk);
        chk(nb == 0 && cs_n == 2'b11, "R9 no channel 1 start", nb, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule